// File: doc/BRIEF.md
# Timebase Timer with Edge Capture

This peripheral keeps an 8-bit up-counter running from an internal prescaler. The counter steps through 0 to 249 and then wraps. The prescaler divides the oscillator by 32 or by 64, so one full wrap takes 8000 or 16000 oscillator cycles. Every wrap raises a timebase flag.

An external capture pin is synchronized and watched for any level change. While the capture flag is clear, a change on the pin freezes the current counter value in a read-only capture register and raises the capture flag. From then on the register is locked until software reads it.

Software reaches the block through a small register bus with two addresses, a control/status register and the capture register. Both flags are cleared by reading, never by writing. A single interrupt line combines each flag with its own enable bit.

Top module: `tbcap_timer`

## Requirements
- R1: After a synchronous active-low reset, the control/status register (bus address 0) reads 00h, the capture register (bus address 1) reads 00h and `irq` is low.
- R2: In the control/status register, bit 7 (capture interrupt enable), bit 5 (period select) and bit 4 (timebase interrupt enable) are written by a bus write and read back as written. Bits 2:0 always read 0 and ignore writes.
- R3: Bit 6 (capture flag) and bit 3 (timebase flag) of the control/status register do not change on a bus write.
- R4: With period select 0, the counter advances once every 32 clock cycles and wraps from 249 to 0. Counting rising edges from the first one with reset released, the timebase flag is set by edge 8000.
- R5: With period select 1, the prescaler divides by 64, and the timebase flag is first set by edge 16000.
- R6: A bus read of the control/status register returns the flags as they are, then clears the timebase flag at that clock edge.
- R7: If a timebase wrap and a clearing read of the control/status register fall on the same clock edge, the timebase flag stays set.
- R8: A rising or a falling level change on `cap_pin` that arrives while the capture flag is clear sets the capture flag and loads the counter. The pin changes after edge N. The flag is visible after edge N+3, and the loaded value is the counter value reached after edge N+2.
- R9: While the capture flag is set, further changes on `cap_pin` leave the capture register unchanged.
- R10: A bus read of the capture register returns the captured value and clears the capture flag, which re-arms capture.
- R11: `irq` is high exactly when (capture flag AND capture enable) OR (timebase flag AND timebase enable).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 control/status, 1 capture |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; triggers flag clearing |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| cap_pin | input | 1 | External capture input, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take several things for granted about the inputs:
- `bus_rd` and `bus_wr` are single-cycle strobes.
- The capture pin is held low during reset, so the synchronizer does not report a false edge when reset is released.
- A pin level is held for at least one clock, so each change is seen as a single edge.

The stimulus respects all of these. It drives the pin and the bus strobes only at falling clock edges, and it holds every pin level for many cycles. It changes the period select only right after reset, so the bench's reference counter stays exact.

// File: rtl/tbcap_pkg.sv
// Shared constants for the timebase/capture timer.
// Assumes an 8-bit register bus with a one-bit register select.
package tbcap_pkg;

    localparam int DATA_W = 8;

    // Register select values
    typedef enum logic {
        SEL_CSR = 1'b0,
        SEL_CAP = 1'b1
    } reg_sel_e;

    // Control/status bit positions (software visible, fixed)
    localparam int B_CAP_IE  = 7;
    localparam int B_CAP_F   = 6;
    localparam int B_PER_SEL = 5;
    localparam int B_TB_IE   = 4;
    localparam int B_TB_F    = 3;

endpackage

// File: rtl/tbcap_counter.sv
// Prescaler and 8-bit up-counter.
// The prescaler divides the clock by PRESC_SHORT, or by twice that when
// long_sel is set. The counter runs from 0 to TICKS-1 and wraps; the wrap
// pulse marks the end of one timebase period.
// Assumes TICKS-1 fits in CNT_W bits.
module tbcap_counter #(
    parameter int PRESC_SHORT = 32,
    parameter int TICKS       = 250,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             long_sel,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam int               PW       = $clog2(2 * PRESC_SHORT) + 1;
    localparam logic [PW-1:0]    LIM_S    = PW'(PRESC_SHORT - 1);
    localparam logic [PW-1:0]    LIM_L    = PW'(2 * PRESC_SHORT - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS - 1);

    logic [PW-1:0] presc_q;
    logic [PW-1:0] presc_lim;
    logic          tick;

    // Select the prescaler terminal count from the period select
    always_comb begin
        presc_lim = long_sel ? LIM_L : LIM_S;
        tick      = (presc_q >= presc_lim);
        wrap      = tick && (cnt == CNT_LAST);
    end

    // Advance the prescaler every clock and the counter on each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
            cnt     <= '0;
        end else if (tick) begin
            presc_q <= '0;
            cnt     <= (cnt == CNT_LAST) ? '0 : cnt + CNT_W'(1);
        end else begin
            presc_q <= presc_q + PW'(1);
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST);                                        // R4
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));                                   // R4

endmodule

// File: rtl/tbcap_edge.sv
// Synchronizer and any-edge detector for the capture pin.
// STAGES flops bring the pin into the clock domain. cap_edge pulses for one
// cycle whenever the synchronized level differs from its previous sample.
// Assumes the pin is held low during reset.
module tbcap_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic cap_edge
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the pin through the synchronizer and keep the last level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Flag a level change on the synchronized pin
    always_comb cap_edge = sync_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/tbcap_regs.sv
// Register file: control/status bits, the two flags and the capture register.
// Flags are set by hardware and cleared only by bus reads. When a set and a
// clear land on the same edge, the set wins. Read data is combinational.
// Assumes single-cycle bus strobes.
module tbcap_regs
    import tbcap_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              wrap,
    input  logic              cap_edge,
    output logic              long_sel,
    output logic              irq
);
    logic             cap_ie_q, tb_ie_q, per_q;
    logic             cap_f_q, tb_f_q;
    logic [CNT_W-1:0] cap_q;
    logic             wr_csr, rd_csr, rd_cap, do_cap;

    // Decode bus strobes and capture qualification
    always_comb begin
        wr_csr = bus_wr && (bus_addr == SEL_CSR);
        rd_csr = bus_rd && (bus_addr == SEL_CSR);
        rd_cap = bus_rd && (bus_addr == SEL_CAP);
        do_cap = cap_edge && !cap_f_q;
    end

    // Software-written control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_ie_q <= 1'b0;
            per_q    <= 1'b0;
            tb_ie_q  <= 1'b0;
        end else if (wr_csr) begin
            cap_ie_q <= bus_wdata[B_CAP_IE];
            per_q    <= bus_wdata[B_PER_SEL];
            tb_ie_q  <= bus_wdata[B_TB_IE];
        end
    end

    // Timebase flag: set on wrap, cleared by a status read, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)       tb_f_q <= 1'b0;
        else if (wrap)    tb_f_q <= 1'b1;
        else if (rd_csr)  tb_f_q <= 1'b0;
    end

    // Capture flag and value: load once, then lock until the value is read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_f_q <= 1'b0;
            cap_q   <= '0;
        end else if (do_cap) begin
            cap_f_q <= 1'b1;
            cap_q   <= cnt;
        end else if (rd_cap) begin
            cap_f_q <= 1'b0;
        end
    end

    // Read mux and interrupt combine
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == SEL_CAP) begin
            bus_rdata = DATA_W'(cap_q);
        end else begin
            bus_rdata[B_CAP_IE]  = cap_ie_q;
            bus_rdata[B_CAP_F]   = cap_f_q;
            bus_rdata[B_PER_SEL] = per_q;
            bus_rdata[B_TB_IE]   = tb_ie_q;
            bus_rdata[B_TB_F]    = tb_f_q;
        end
        long_sel = per_q;
        irq      = (cap_f_q && cap_ie_q) || (tb_f_q && tb_ie_q);
    end

    AST_TB_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> tb_f_q);                                        // R7
    AST_TB_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && !wrap) |=> $stable(tb_f_q));       // R3
    AST_CAP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_f_q && !rd_cap) |=> ($stable(cap_q) && cap_f_q));   // R9
    AST_CAP_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_edge && !cap_f_q) |=> cap_f_q);                     // R8

endmodule

// File: rtl/tbcap_timer.sv
// Top: timebase timer with input capture on a small register bus.
// Wires the prescaled counter, the capture pin synchronizer and the
// register file. Assumes cap_pin is low during reset.
module tbcap_timer #(
    parameter int PRESC_SHORT = 32,
    parameter int TICKS       = 250,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       cap_pin,
    output logic       irq
);
    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic             cap_edge;
    logic             long_sel;

    tbcap_counter #(
        .PRESC_SHORT(PRESC_SHORT),
        .TICKS      (TICKS),
        .CNT_W      (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .long_sel(long_sel),
        .cnt     (cnt),
        .wrap    (wrap)
    );

    tbcap_edge #(
        .STAGES(SYNC_STAGES)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (cap_pin),
        .cap_edge(cap_edge)
    );

    tbcap_regs #(
        .CNT_W(CNT_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cnt      (cnt),
        .wrap     (wrap),
        .cap_edge (cap_edge),
        .long_sel (long_sel),
        .irq      (irq)
    );

endmodule

// File: tb/tb_tbcap_timer.sv
module tb_tbcap_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cap_pin = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    int ecount = 0;

    tbcap_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_pin(cap_pin), .irq(irq)
    );

    always #5 clk = ~clk;

    // Rising edges counted since reset release
    always @(posedge clk) begin
        if (!rst_n) ecount <= 0;
        else        ecount <= ecount + 1;
    end

    // Stimulus: {write data, expected read-back}
    localparam logic [15:0] CSR_VEC [8] = '{
        16'hFF_B0, 16'h00_00, 16'h48_00, 16'h80_80,
        16'h20_20, 16'h10_10, 16'h07_00, 16'hA5_A0
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cap_pin = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_until(input int n);
        while (ecount < n) @(negedge clk);
    endtask

    task automatic peek(input logic a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic int cnt_at(input int e);
        return (e / 32) % 250;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        logic [7:0] d;

        // Reset state
        do_reset();
        peek(1'b0, d); chk("R1 csr", d, 8'h00);
        peek(1'b1, d); chk("R1 cap", d, 8'h00);
        chk("R1 irq", irq, 0);

        // Control bit write/read-back table
        for (int i = 0; i < 8; i++) begin
            bus_write(1'b0, CSR_VEC[i][15:8]);
            peek(1'b0, d);
            chk((i == 2) ? "R3 flags write" : "R2 csr rw", d, CSR_VEC[i][7:0]);
        end

        // Capture
        do_reset();
        bus_write(1'b0, 8'h80);
        wait_until(100); cap_pin = 1'b1;
        wait_until(102); peek(1'b0, d); chk("R8 flag not yet", d[6], 0);
        wait_until(103); peek(1'b0, d); chk("R8 flag", d[6], 1);
        peek(1'b1, d); chk("R8 rising value", d, cnt_at(102));
        chk("R11 irq cap", irq, 1);
        wait_until(150); cap_pin = 1'b0;
        wait_until(200); peek(1'b1, d); chk("R9 locked", d, cnt_at(102));
        bus_read(1'b1, d); chk("R10 read value", d, cnt_at(102));
        peek(1'b0, d); chk("R10 flag cleared", d[6], 0);
        chk("R11 irq drop", irq, 0);
        wait_until(300); cap_pin = 1'b1;
        wait_until(303); peek(1'b1, d); chk("R10 rearmed", d, cnt_at(302));
        bus_read(1'b1, d);
        wait_until(400); cap_pin = 1'b0;
        wait_until(403); peek(1'b1, d); chk("R8 falling value", d, cnt_at(402));
        bus_read(1'b1, d);
        bus_write(1'b0, 8'h40);
        peek(1'b0, d); chk("R3 cap flag write", d, 8'h00);

        // Timebase, short period
        do_reset();
        wait_until(7999); peek(1'b0, d); chk("R4 before wrap", d[3], 0);
        wait_until(8000); peek(1'b0, d); chk("R4 at wrap", d[3], 1);
        chk("R11 irq masked", irq, 0);
        bus_write(1'b0, 8'h10);
        chk("R11 irq tb", irq, 1);
        bus_read(1'b0, d); chk("R6 read value", d, 8'h18);
        peek(1'b0, d); chk("R6 cleared", d, 8'h10);
        chk("R11 irq cleared", irq, 0);
        bus_write(1'b0, 8'h18);
        peek(1'b0, d); chk("R3 tb flag write", d, 8'h10);
        wait_until(15999);
        bus_addr = 1'b0; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        peek(1'b0, d); chk("R7 set wins", d[3], 1);

        // Timebase, long period
        do_reset();
        bus_write(1'b0, 8'h20);
        wait_until(15999); peek(1'b0, d); chk("R5 before wrap", d, 8'h20);
        wait_until(16000); peek(1'b0, d); chk("R5 at wrap", d, 8'h28);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule